// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt

This block watches the time-of-day and calendar counters of a real-time clock and raises an alarm when they reach a programmed point. It holds six alarm registers, one each for seconds, minutes, hours, day of month, month and weekday. In each register, bit 7 turns that field on and the low seven bits hold the BCD value to compare. Only the fields that are turned on take part in the match. This allows partial alarms such as "every minute at second 30" or "every Wednesday at 07:15".

The comparison runs once for each one-second tick, in the tick cycle, after the counters have updated. One matching second therefore gives exactly one alarm event. Each event sets a status flag. The flag stays set until software clears it.

An interrupt control register selects how the active-low interrupt pin behaves:
- **Repeating mode:** the pin pulses low for a fixed number of clock cycles on every event, and the status flag never needs clearing.
- **Level mode:** the pin stays low for as long as the status flag is set.
- **Disabled:** the pin stays high, and the status flag still records events.

Top module: `alarm_match_unit`

## Requirements
- R1: After a synchronous reset (active-low `rst_n`), all six alarm registers and the control register read 00h, the status flag is 0 and `irq_n_o` is high.
- R2: Register map on `reg_addr_i`: 0 seconds alarm, 1 minutes, 2 hours, 3 day of month, 4 month, 5 weekday, 6 interrupt control, 7 status (flag in bit 0, other bits 0). Writing with `wr_en_i` stores `wr_data_i` at a clock edge. `rd_data_o` shows the addressed register combinationally.
- R3: In an alarm register, bit 7 = 1 turns the field on, and bits 6:0 are compared with the 7-bit BCD counter of that field. A match needs every field that is on to be equal.
- R4: A field whose bit 7 is 0 (for example a register value of 00h) has no effect on the match, whatever its counter value.
- R5: If no field is turned on, no alarm event ever occurs.
- R6: The match is evaluated only in cycles where `tick_i` is 1. Equal values without a tick produce no event.
- R7: An event sets `status_o` from the next cycle on. Later events leave it set. Only a write to address 7 with bit 0 = 0 clears it, and a write with bit 0 = 1 has no effect. If a clear and an event fall in the same cycle, the event wins.
- R8: With control bits 7:6 = 11 (repeating mode), `irq_n_o` goes low from the cycle after each event for exactly PULSE_CYCLES cycles (4 by default). Every later event pulses it again, with no need to clear the status flag.
- R9: With control bits 7:6 = 10 (level mode), `irq_n_o` is low exactly while the status flag is set.
- R10: With control bit 7 = 0, `irq_n_o` stays high, and events still set the status flag.
- R11: An event that arrives while a repeating-mode pulse is active restarts the low time at a full PULSE_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle one-second tick; counters already updated |
| sec_i | input | 7 | BCD seconds counter |
| min_i | input | 7 | BCD minutes counter |
| hour_i | input | 7 | BCD hours counter |
| date_i | input | 7 | BCD day-of-month counter |
| month_i | input | 7 | BCD month counter |
| dow_i | input | 7 | Weekday counter |
| wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for write and read |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Read data of the addressed register |
| irq_n_o | output | 1 | Active-low alarm interrupt |
| status_o | output | 1 | Alarm status flag |

## Verification
The match logic is tried with several kinds of alarm setting:
- **Seconds only, at 30:** matching and non-matching second values separate the compare from the field enable, and a second matching tick shows that pulses repeat without clearing.
- **Four fields on at once (seconds, minutes, weekday, day of month):** one field at a time is made to differ, which shows that every field that is on takes part. In the same pattern a disabled hour field carries an arbitrary counter value, which shows it is ignored.
- **All fields off with zero counters, and matching counters with no tick:** these two patterns separate "no field enabled" from "no evaluation".
- **The three interrupt modes and a retrigger in the middle of a pulse:** measuring the low time tells the pulse length, the restart and the level behaviour apart.

// File: rtl/alarm_pkg.sv
`timescale 1ns/1ps
// Package: shared constants of the calendar alarm comparator.
// Assumes field order seconds..weekday maps to register addresses 0..5.
package alarm_pkg;
    localparam int ALARM_FIELDS  = 6;   // number of compared calendar fields
    localparam int ALARM_DW      = 8;   // register width
    localparam int ALARM_AW      = 3;   // register address width
    localparam int FIELD_EN_BIT  = 7;   // per-field enable position
    localparam int CTRL_EN_BIT   = 7;   // interrupt enable position
    localparam int CTRL_REP_BIT  = 6;   // repeating-mode position

    typedef enum logic [ALARM_AW-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4,
        FLD_DOW   = 3'd5,
        REG_CTRL  = 3'd6,
        REG_STAT  = 3'd7
    } alarm_addr_e;
endpackage

// File: rtl/alarm_regfile.sv
`timescale 1ns/1ps
// Module: alarm_regfile
// Holds the alarm field registers and the interrupt control register,
// provides a combinational read mux and decodes the status-clear write.
// Assumes NFIELD+2 addresses fit in AW bits.
module alarm_regfile #(
    parameter int NFIELD = 6,
    parameter int DW     = 8,
    parameter int AW     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic                   status,
    output logic [NFIELD-1:0][DW-1:0] alarm_q,
    output logic [DW-1:0]          ctrl_q,
    output logic                   status_clr,
    output logic [DW-1:0]          rdata
);
    localparam logic [AW-1:0] CTRL_ADDR = AW'(NFIELD);
    localparam logic [AW-1:0] STAT_ADDR = AW'(NFIELD + 1);

    generate
        for (genvar g = 0; g < NFIELD; g++) begin : g_field
            // Purpose: store one alarm field register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    alarm_q[g] <= '0;
                else if (wr_en && addr == AW'(g))
                    alarm_q[g] <= wdata;
            end
        end
    endgenerate

    // Purpose: store the interrupt control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && addr == CTRL_ADDR)
            ctrl_q <= wdata;
    end

    // Purpose: a status write with bit 0 low requests a clear.
    assign status_clr = wr_en && (addr == STAT_ADDR) && !wdata[0];

    // Purpose: select the addressed register for reading.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NFIELD; i++) begin
            if (addr == AW'(i))
                rdata = alarm_q[i];
        end
        if (addr == CTRL_ADDR)
            rdata = ctrl_q;
        if (addr == STAT_ADDR)
            rdata = {{(DW-1){1'b0}}, status};
    end
endmodule

// File: rtl/alarm_compare.sv
`timescale 1ns/1ps
// Module: alarm_compare
// Compares each enabled alarm field with its counter; hit is high when at
// least one field is enabled and all enabled fields are equal.
// Assumes the enable sits in the top register bit, value in the rest.
module alarm_compare #(
    parameter int NFIELD = 6,
    parameter int DW     = 8
) (
    input  logic [NFIELD-1:0][DW-1:0] alarm_q,
    input  logic [NFIELD-1:0][DW-2:0] counts,
    output logic                      hit
);
    logic [NFIELD-1:0] fld_on;
    logic [NFIELD-1:0] fld_eq;

    generate
        for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
            // Purpose: per-field enable and equality.
            assign fld_on[g] = alarm_q[g][DW-1];
            assign fld_eq[g] = (alarm_q[g][DW-2:0] == counts[g]);
        end
    endgenerate

    // Purpose: combine fields; disabled fields pass, none enabled blocks.
    assign hit = (|fld_on) && (&(~fld_on | fld_eq));
endmodule

// File: rtl/alarm_irq_gen.sv
`timescale 1ns/1ps
// Module: alarm_irq_gen
// Keeps the sticky status flag and the pulse timer, and forms the
// active-low interrupt from the selected mode.
// Assumes fire is a single-cycle event strobe.
module alarm_irq_gen #(
    parameter int PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic status_clr,
    input  logic int_en,
    input  logic rep_mode,
    output logic status,
    output logic irq_n
);
    localparam int CW = $clog2(PULSE + 1);
    localparam logic [CW-1:0] PULSE_LD = CW'(PULSE);

    logic [CW-1:0] pulse_cnt;

    // Purpose: sticky status; an event outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= 1'b0;
        else if (fire)
            status <= 1'b1;
        else if (status_clr)
            status <= 1'b0;
    end

    // Purpose: load the pulse length on each event, count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_cnt <= '0;
        else if (fire)
            pulse_cnt <= PULSE_LD;
        else if (pulse_cnt != '0)
            pulse_cnt <= pulse_cnt - 1'b1;
    end

    // Purpose: drive the pin low per mode.
    assign irq_n = !(int_en && (rep_mode ? (pulse_cnt != '0) : status));
endmodule

// File: rtl/alarm_match_unit.sv
`timescale 1ns/1ps
// Module: alarm_match_unit (top)
// Calendar alarm comparator: six enable-per-field alarm registers, a
// match evaluated on each one-second tick, a sticky status flag and an
// active-low interrupt with repeating-pulse or level behaviour.
// Assumes counters are valid in the tick cycle.
module alarm_match_unit
    import alarm_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [ALARM_DW-2:0] sec_i,
    input  logic [ALARM_DW-2:0] min_i,
    input  logic [ALARM_DW-2:0] hour_i,
    input  logic [ALARM_DW-2:0] date_i,
    input  logic [ALARM_DW-2:0] month_i,
    input  logic [ALARM_DW-2:0] dow_i,
    input  logic                wr_en_i,
    input  logic [ALARM_AW-1:0] reg_addr_i,
    input  logic [ALARM_DW-1:0] wr_data_i,
    output logic [ALARM_DW-1:0] rd_data_o,
    output logic                irq_n_o,
    output logic                status_o
);
    logic [ALARM_FIELDS-1:0][ALARM_DW-1:0] alarm_regs;
    logic [ALARM_FIELDS-1:0][ALARM_DW-2:0] cnt_vec;
    logic [ALARM_DW-1:0]                   ctrl_reg;
    logic                                  stat_clr;
    logic                                  hit;
    logic                                  fire;

    // Purpose: gather counters in field order (index = register address).
    assign cnt_vec[FLD_SEC]   = sec_i;
    assign cnt_vec[FLD_MIN]   = min_i;
    assign cnt_vec[FLD_HOUR]  = hour_i;
    assign cnt_vec[FLD_DATE]  = date_i;
    assign cnt_vec[FLD_MONTH] = month_i;
    assign cnt_vec[FLD_DOW]   = dow_i;

    alarm_regfile #(
        .NFIELD (ALARM_FIELDS),
        .DW     (ALARM_DW),
        .AW     (ALARM_AW)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en_i),
        .addr       (reg_addr_i),
        .wdata      (wr_data_i),
        .status     (status_o),
        .alarm_q    (alarm_regs),
        .ctrl_q     (ctrl_reg),
        .status_clr (stat_clr),
        .rdata      (rd_data_o)
    );

    alarm_compare #(
        .NFIELD (ALARM_FIELDS),
        .DW     (ALARM_DW)
    ) cmp_i (
        .alarm_q (alarm_regs),
        .counts  (cnt_vec),
        .hit     (hit)
    );

    // Purpose: evaluate the match only in tick cycles.
    assign fire = tick_i && hit;

    alarm_irq_gen #(
        .PULSE (PULSE_CYCLES)
    ) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .status_clr (stat_clr),
        .int_en     (ctrl_reg[CTRL_EN_BIT]),
        .rep_mode   (ctrl_reg[CTRL_REP_BIT]),
        .status     (status_o),
        .irq_n      (irq_n_o)
    );
endmodule

// File: rtl/alarm_match_unit_chk.sv
`timescale 1ns/1ps
// Module: alarm_match_unit_chk
// Checker bound to alarm_match_unit; watches ports and register outputs.
module alarm_match_unit_chk #(
    parameter int NFIELD = 6,
    parameter int DW     = 8,
    parameter int AW     = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      tick_i,
    input logic                      wr_en_i,
    input logic [AW-1:0]             reg_addr_i,
    input logic                      wr_bit0,
    input logic [NFIELD-1:0][DW-1:0] alarm_regs,
    input logic [DW-1:0]             ctrl_reg,
    input logic                      status_o,
    input logic                      irq_n_o
);
    localparam logic [AW-1:0] STAT_ADDR = AW'(NFIELD + 1);

    logic any_on;
    logic rep_on;

    // Purpose: observe whether any field enable is set.
    always_comb begin
        any_on = 1'b0;
        for (int i = 0; i < NFIELD; i++)
            any_on = any_on | alarm_regs[i][DW-1];
    end

    assign rep_on = ctrl_reg[DW-1] && ctrl_reg[DW-2];

    // R1: a reset cycle leaves the outputs idle.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_n_o && !status_o));

    // R5: no enabled field never sets status.
    assert_no_field_no_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !any_on && !status_o) |=> !status_o);

    // R6: without a tick status cannot rise.
    assert_tick_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !status_o) |=> !status_o);

    // R7: status holds unless a clear write occurs.
    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !(wr_en_i && reg_addr_i == STAT_ADDR && !wr_bit0)) |=> status_o);

    // R8: in repeating mode a falling pin follows a tick.
    assert_pulse_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_n_o) && rep_on && $past(rep_on)) |-> $past(tick_i));
endmodule

bind alarm_match_unit alarm_match_unit_chk #(
    .NFIELD (alarm_pkg::ALARM_FIELDS),
    .DW     (alarm_pkg::ALARM_DW),
    .AW     (alarm_pkg::ALARM_AW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .reg_addr_i (reg_addr_i),
    .wr_bit0    (wr_data_i[0]),
    .alarm_regs (alarm_regs),
    .ctrl_reg   (ctrl_reg),
    .status_o   (status_o),
    .irq_n_o    (irq_n_o)
);

// File: tb/alarm_match_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios for alarm_match_unit, one task per scenario.
module alarm_match_unit_tb_top;
    localparam int PULSE = 4;
    localparam int WATCH = PULSE + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [6:0] sec_i = '0, min_i = '0, hour_i = '0;
    logic [6:0] date_i = '0, month_i = '0, dow_i = '0;
    logic       wr_en_i = 1'b0;
    logic [2:0] reg_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_n_o;
    logic       status_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    alarm_match_unit #(.PULSE_CYCLES(PULSE)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i),
        .date_i(date_i), .month_i(month_i), .dow_i(dow_i),
        .wr_en_i(wr_en_i), .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .irq_n_o(irq_n_o), .status_o(status_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; reg_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a;
        #1 d = rd_data_o;
    endtask

    task automatic set_time(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                            input logic [6:0] dt, input logic [6:0] mo, input logic [6:0] dw);
        sec_i = s; min_i = m; hour_i = h; date_i = dt; month_i = mo; dow_i = dw;
    endtask

    // Tick once, then count low cycles of irq_n over a window.
    task automatic tick_watch(output int lows);
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        lows = 0;
        repeat (WATCH) begin
            if (!irq_n_o) lows++;
            @(negedge clk);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < 7; i++) write_reg(3'(i), 8'h00);
        write_reg(3'd7, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check(irq_n_o === 1'b1, "R1 irq_n after reset", irq_n_o, 1);
        check(status_o === 1'b0, "R1 status after reset", status_o, 0);
        for (int i = 0; i < 8; i++) begin
            read_reg(3'(i), d);
            check(d === 8'h00, "R1 register reset value", d, 0);
        end
    endtask

    task automatic t_regs();
        logic [7:0] d;
        for (int i = 0; i < 7; i++) write_reg(3'(i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 7; i++) begin
            read_reg(3'(i), d);
            check(d === 8'(8'h11 * (i + 1)), "R2 readback", d, 8'h11 * (i + 1));
        end
        clear_all();
    endtask

    task automatic t_seconds_repeat();
        int lows;
        write_reg(3'd0, 8'hB0);
        write_reg(3'd6, 8'hC0);
        set_time(7'h30, 7'h12, 7'h08, 7'h01, 7'h01, 7'h02);
        tick_watch(lows);
        check(lows == PULSE, "R8 pulse length", lows, PULSE);
        check(status_o === 1'b1, "R7 status set", status_o, 1);
        set_time(7'h31, 7'h12, 7'h08, 7'h01, 7'h01, 7'h02);
        tick_watch(lows);
        check(lows == 0, "R3 second mismatch", lows, 0);
        set_time(7'h30, 7'h13, 7'h08, 7'h01, 7'h01, 7'h02);
        tick_watch(lows);
        check(lows == PULSE, "R8 repeat without clear", lows, PULSE);
        clear_all();
    endtask

    task automatic t_multi_field();
        int lows;
        write_reg(3'd0, 8'h80);   // sec 00
        write_reg(3'd1, 8'h85);   // min 05
        write_reg(3'd3, 8'h95);   // date 15
        write_reg(3'd5, 8'h83);   // dow 3
        write_reg(3'd6, 8'hC0);
        set_time(7'h00, 7'h05, 7'h17, 7'h15, 7'h06, 7'h03);
        tick_watch(lows);
        check(lows == PULSE, "R3 all enabled equal", lows, PULSE);
        check(status_o === 1'b1, "R4 disabled hour ignored", status_o, 1);
        set_time(7'h00, 7'h06, 7'h17, 7'h15, 7'h06, 7'h03);
        tick_watch(lows);
        check(lows == 0, "R3 minute differs", lows, 0);
        set_time(7'h00, 7'h05, 7'h17, 7'h15, 7'h06, 7'h04);
        tick_watch(lows);
        check(lows == 0, "R3 weekday differs", lows, 0);
        set_time(7'h00, 7'h05, 7'h17, 7'h16, 7'h06, 7'h03);
        tick_watch(lows);
        check(lows == 0, "R3 date differs", lows, 0);
        set_time(7'h00, 7'h05, 7'h23, 7'h15, 7'h11, 7'h03);
        tick_watch(lows);
        check(lows == PULSE, "R4 disabled hour and month vary", lows, PULSE);
        clear_all();
    endtask

    task automatic t_none_enabled();
        int lows;
        write_reg(3'd6, 8'hC0);
        set_time('0, '0, '0, '0, '0, '0);
        tick_watch(lows);
        check(lows == 0, "R5 no field no pulse", lows, 0);
        check(status_o === 1'b0, "R5 no field no status", status_o, 0);
        clear_all();
    endtask

    task automatic t_no_tick();
        write_reg(3'd0, 8'hB0);
        write_reg(3'd6, 8'hC0);
        set_time(7'h30, '0, '0, '0, '0, '0);
        repeat (WATCH) @(negedge clk);
        check(irq_n_o === 1'b1, "R6 no tick irq", irq_n_o, 1);
        check(status_o === 1'b0, "R6 no tick status", status_o, 0);
        clear_all();
    endtask

    task automatic t_status();
        int lows;
        logic [7:0] d;
        write_reg(3'd0, 8'hB0);
        write_reg(3'd6, 8'hC0);
        set_time(7'h30, '0, '0, '0, '0, '0);
        tick_watch(lows);
        read_reg(3'd7, d);
        check(d === 8'h01, "R7 status readback", d, 1);
        write_reg(3'd7, 8'h01);
        check(status_o === 1'b1, "R7 write one no effect", status_o, 1);
        write_reg(3'd7, 8'h00);
        check(status_o === 1'b0, "R7 write zero clears", status_o, 0);
        // clear and event in the same cycle: event wins
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; reg_addr_i = 3'd7; wr_data_i = 8'h00;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        check(status_o === 1'b1, "R7 event beats clear", status_o, 1);
        repeat (WATCH) @(negedge clk);
        clear_all();
    endtask

    task automatic t_level();
        int lows;
        write_reg(3'd0, 8'hB0);
        write_reg(3'd6, 8'h80);
        set_time(7'h30, '0, '0, '0, '0, '0);
        tick_watch(lows);
        check(lows == WATCH, "R9 level held low", lows, WATCH);
        write_reg(3'd7, 8'h00);
        check(irq_n_o === 1'b1, "R9 released by clear", irq_n_o, 1);
        clear_all();
    endtask

    task automatic t_int_off();
        int lows;
        write_reg(3'd0, 8'hB0);
        set_time(7'h30, '0, '0, '0, '0, '0);
        tick_watch(lows);
        check(lows == 0, "R10 irq stays high", lows, 0);
        check(status_o === 1'b1, "R10 status still sets", status_o, 1);
        clear_all();
    endtask

    task automatic t_retrigger();
        int lows;
        write_reg(3'd0, 8'hB0);
        write_reg(3'd6, 8'hC0);
        set_time(7'h30, '0, '0, '0, '0, '0);
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        lows = 0;
        for (int c = 0; c < 12; c++) begin
            if (!irq_n_o) lows++;
            if (c == 2) tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
        check(lows == PULSE + 3, "R11 retrigger restarts", lows, PULSE + 3);
        clear_all();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_seconds_repeat();
        t_multi_field();
        t_none_enabled();
        t_no_tick();
        t_status();
        t_level();
        t_int_off();
        t_retrigger();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule